// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a 16-bit processor whose address and data share one set of lines. A core asks for a read, a write or an interrupt acknowledge. It supplies a 20-bit address, write data, a byte flag and a memory/I/O flag. The sequencer then steps through the bus T-states T1, T2, T3, any number of wait states TW, and T4. In each state it drives the address latch enable, the lane strobes, the read, write and acknowledge strobes, and the direction and enable lines for an external bus transceiver.

Each T-state lasts two clocks. This lets the write strobe start at the beginning of T2 while the read strobe starts half a state later, after the address drivers have let go of the shared lines. Read data comes back aligned to bit 0. An interrupt acknowledge always runs as two cycles, one straight after the other. The type byte read in the second cycle is returned multiplied by four as a vector-table pointer.

Top module: `mbus_seq`

## Requirements
- R1: A request is taken when `req_start` is high at a clock edge while `busy` is low, with `req_op` 0 = read, 1 = write, 2 = interrupt acknowledge. Code 3 starts nothing. `busy` rises in the next clock. Each T-state lasts two clocks, in the order T1, T2, T3, zero or more TW, T4. `done` is high in the last clock of T4, and `busy` is low in the clock after it.
- R2: `ale` is high for both clocks of T1 in every cycle and low at all other times. `a_hi` carries address bits 19:16 from T1 of a read or write until the next read or write.
- R3: In a write, `ad_oe` is high from T1 through the first clock of T4. `ad_out` carries the write data from the first clock of T2. `wr_n` is low for all of T2, T3 and every TW.
- R4: In a read, `rd_n` is low from the second clock of T2 through T3 and every TW. `ad_oe` is high only in T1.
- R5: `ready` is looked at only in the second clock of T3 and of each TW. A low sample adds one more TW, and a high sample moves on to T4.
- R6: `io_sel` is high during a cycle for an I/O access or an acknowledge, and low otherwise. `dt_r` is low during read and acknowledge cycles and high otherwise. `den_n` is low during a write from T2 through the first clock of T4. During a read or acknowledge, `den_n` is low while the read or acknowledge strobe is low and in the first clock of T4.
- R7: Lane select `{bhe_n, A0}`, with A0 = `ad_out[0]` in T1, works as follows. A word at an even address gives 00, drives all 16 write bits and returns all 16 read bits. A byte at an even address gives 10 and uses bits 7:0. A byte at an odd address, or a word at an odd address, gives 01 and uses bits 15:8. During an acknowledge and when idle, `bhe_n` is 1. A byte written on bits 15:8 leaves bits 7:0 zero, and the reverse.
- R8: `rdata` takes `ad_in` in the clock in which `ready` is accepted. The selected byte is zero-extended into bits 7:0. The value shows from the first clock of T4 and holds until the next read.
- R9: An acknowledge request runs two cycles with no idle clock between them. `inta_n` takes the place of `rd_n`, and `ad_oe` stays low throughout. Whenever `ad_out` is not carrying write data, it and `a_hi` show the last read or write address. `done` is raised only at the end of the second cycle.
- R10: `vec_ptr` becomes `ad_in[7:0]` × 4, taken when `ready` is accepted in the second acknowledge cycle. The byte seen in the first cycle has no effect.
- R11: `req_start` and the request fields are ignored while `busy` is high.
- R12: During and after reset, the outputs show idle. All strobes are high, `dt_r` is high, `ale`, `ad_oe`, `io_sel`, `busy` and `done` are low, and `ad_out`, `a_hi`, `rdata` and `vec_ptr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 interrupt acknowledge |
| req_io | input | 1 | 1 selects I/O space |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data, a byte in bits 7:0 |
| req_byte | input | 1 | 1 for a single-byte transfer |
| ready | input | 1 | Ends wait states when high |
| ad_in | input | 16 | Value read from the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| a_hi | output | 4 | Address bits 19:16 |
| ale | output | 1 | Address latch enable |
| io_sel | output | 1 | High for I/O space |
| bhe_n | output | 1 | High byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| dt_r | output | 1 | Transceiver direction, high = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last clock of a finished request |
| rdata | output | 16 | Aligned read data |
| vec_ptr | output | 10 | Interrupt type × 4 |

## Verification
The bench runs five kinds of traffic against its own model:
- Word reads and writes at even addresses, which separate the early write strobe from the late read strobe.
- Byte reads and writes at both address parities, plus a word at an odd address, which separate the three lane codes and the alignment of the returned byte.
- Runs of zero to three wait states with `ready` held low on every clock where it must be ignored, which separate correct sampling from sampling in the wrong half of a state.
- An acknowledge pair whose two cycles see different bytes, which shows that only the second byte becomes the pointer and that the address lines hold.
- An unused op code, and a second request held high throughout a busy cycle, which both have to leave the bus untouched.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_TW   = 3'd4,
      TS_T4   = 3'd5
   } tstate_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_ACK   = 2'd2
   } op_e;
endpackage

// File: rtl/mbus_tseq.sv
module mbus_tseq
   import mbus_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  op_e     op_in,
   input  logic    io_in,
   input  logic    ready,
   output tstate_e state,
   output logic    ph,
   output op_e     op,
   output logic    io,
   output logic    ack2,
   output logic    cap,
   output logic    done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TS_IDLE;
         ph    <= 1'b0;
         op    <= OP_READ;
         io    <= 1'b0;
         ack2  <= 1'b0;
      end else if (state == TS_IDLE) begin
         if (start) begin
            state <= TS_T1;
            op    <= op_in;
            io    <= io_in;
            ack2  <= 1'b0;
         end
      end else begin
         ph <= ~ph;
         if (ph) begin
            case (state)
               TS_T1:        state <= TS_T2;
               TS_T2:        state <= TS_T3;
               TS_T3, TS_TW: state <= ready ? TS_T4 : TS_TW;
               TS_T4: begin
                  if (op == OP_ACK && !ack2) begin
                     state <= TS_T1;
                     ack2  <= 1'b1;
                  end else begin
                     state <= TS_IDLE;
                  end
               end
               default:      state <= TS_IDLE;
            endcase
         end
      end
   end

   // ready counts only in the closing clock of T3 or a wait state
   assign cap  = ph && (state == TS_T3 || state == TS_TW) && ready;
   assign done = ph && (state == TS_T4) && (op != OP_ACK || ack2);
endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
   import mbus_pkg::*;
#(
   parameter bit RD_LATE = 1'b1
)(
   input  tstate_e state,
   input  logic    ph,
   input  op_e     op,
   input  logic    io,
   output logic    ale,
   output logic    io_sel,
   output logic    rd_n,
   output logic    wr_n,
   output logic    inta_n,
   output logic    dt_r,
   output logic    den_n,
   output logic    busy
);
   logic act, mid, t4a, rstb, is_wr;

   assign act   = (state != TS_IDLE);
   assign mid   = (state == TS_T2) || (state == TS_T3) || (state == TS_TW);
   assign t4a   = (state == TS_T4) && !ph;
   assign is_wr = (op == OP_WRITE);

   generate
      if (RD_LATE) begin : g_rd_late
         assign rstb = (state == TS_T2 && ph) || state == TS_T3 || state == TS_TW;
      end else begin : g_rd_early
         assign rstb = mid;
      end
   endgenerate

   assign ale    = (state == TS_T1);
   assign busy   = act;
   assign io_sel = act && (io || op == OP_ACK);
   assign wr_n   = !(act && is_wr && mid);
   assign rd_n   = !(act && op == OP_READ && rstb);
   assign inta_n = !(act && op == OP_ACK && rstb);
   assign dt_r   = !(act && !is_wr);
   assign den_n  = !(act && ((is_wr ? mid : rstb) || t4a));
endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes
   import mbus_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int TYPE_W    = 8,
   parameter int VEC_SHIFT = 2
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  op_e                         op_in,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        byte_in,
   input  tstate_e                     state,
   input  logic                        ph,
   input  op_e                         op,
   input  logic                        ack2,
   input  logic                        cap,
   input  logic [DATA_W-1:0]           ad_in,
   output logic [DATA_W-1:0]           ad_out,
   output logic                        ad_oe,
   output logic [ADDR_W-DATA_W-1:0]    a_hi,
   output logic                        bhe_n,
   output logic [DATA_W-1:0]           rdata,
   output logic [TYPE_W+VEC_SHIFT-1:0] vec_ptr
);
   localparam int BYTE_W = DATA_W / 2;

   logic [ADDR_W-1:0] a_l;
   logic [DATA_W-1:0] w_l, lane_w, lane_r;
   logic              byte_l, odd, whole, act, wr_data_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_l    <= '0;
         w_l    <= '0;
         byte_l <= 1'b0;
      end else if (load && op_in != OP_ACK) begin
         a_l    <= addr;
         w_l    <= wdata;
         byte_l <= byte_in;
      end
   end

   assign odd   = a_l[0];
   assign whole = !byte_l && !odd;
   assign act   = (state != TS_IDLE);

   assign lane_w = whole ? w_l :
                   odd   ? {w_l[BYTE_W-1:0], {BYTE_W{1'b0}}} :
                           {{BYTE_W{1'b0}}, w_l[BYTE_W-1:0]};
   assign lane_r = whole ? ad_in :
                   odd   ? {{BYTE_W{1'b0}}, ad_in[DATA_W-1:BYTE_W]} :
                           {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]};

   assign wr_data_ph = act && op == OP_WRITE && state != TS_T1;
   assign ad_out     = wr_data_ph ? lane_w : a_l[DATA_W-1:0];
   assign ad_oe      = (state == TS_T1 && op != OP_ACK) ||
                       (op == OP_WRITE && (state inside {TS_T2, TS_T3, TS_TW} ||
                                           (state == TS_T4 && !ph)));
   assign a_hi       = a_l[ADDR_W-1:DATA_W];
   assign bhe_n      = !(act && op != OP_ACK && (whole || odd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata   <= '0;
         vec_ptr <= '0;
      end else if (cap) begin
         if (op == OP_READ)
            rdata <= lane_r;
         if (op == OP_ACK && ack2)
            vec_ptr <= {ad_in[TYPE_W-1:0], {VEC_SHIFT{1'b0}}};
      end
   end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int TYPE_W    = 8,
   parameter int VEC_SHIFT = 2,
   parameter bit RD_LATE   = 1'b1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_start,
   input  logic [1:0]                  req_op,
   input  logic                        req_io,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic                        req_byte,
   input  logic                        ready,
   input  logic [DATA_W-1:0]           ad_in,
   output logic [DATA_W-1:0]           ad_out,
   output logic                        ad_oe,
   output logic [ADDR_W-DATA_W-1:0]    a_hi,
   output logic                        ale,
   output logic                        io_sel,
   output logic                        bhe_n,
   output logic                        rd_n,
   output logic                        wr_n,
   output logic                        inta_n,
   output logic                        dt_r,
   output logic                        den_n,
   output logic                        busy,
   output logic                        done,
   output logic [DATA_W-1:0]           rdata,
   output logic [TYPE_W+VEC_SHIFT-1:0] vec_ptr
);
   generate
      if (ADDR_W <= DATA_W) begin : g_bad_addr
         $error("mbus_seq: ADDR_W must exceed DATA_W");
      end
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("mbus_seq: DATA_W must hold two whole bytes");
      end
      if (TYPE_W > DATA_W / 2) begin : g_bad_type
         $error("mbus_seq: TYPE_W must fit the low lane");
      end
   endgenerate

   tstate_e state;
   op_e     op, op_in;
   logic    ph, io, ack2, cap, start;

   assign op_in = op_e'(req_op);
   assign start = req_start && (state == TS_IDLE) && (req_op != 2'd3);

   mbus_tseq u_tseq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .op_in (op_in),
      .io_in (req_io),
      .ready (ready),
      .state (state),
      .ph    (ph),
      .op    (op),
      .io    (io),
      .ack2  (ack2),
      .cap   (cap),
      .done  (done)
   );

   mbus_strobe #(.RD_LATE(RD_LATE)) u_strobe (
      .state  (state),
      .ph     (ph),
      .op     (op),
      .io     (io),
      .ale    (ale),
      .io_sel (io_sel),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .inta_n (inta_n),
      .dt_r   (dt_r),
      .den_n  (den_n),
      .busy   (busy)
   );

   mbus_lanes #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .TYPE_W    (TYPE_W),
      .VEC_SHIFT (VEC_SHIFT)
   ) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .op_in   (op_in),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .byte_in (req_byte),
      .state   (state),
      .ph      (ph),
      .op      (op),
      .ack2    (ack2),
      .cap     (cap),
      .ad_in   (ad_in),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .a_hi    (a_hi),
      .bhe_n   (bhe_n),
      .rdata   (rdata),
      .vec_ptr (vec_ptr)
   );
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
   parameter int AHI_W = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             ale,
   input logic             ad_oe,
   input logic [AHI_W-1:0] a_hi,
   input logic             rd_n,
   input logic             wr_n,
   input logic             inta_n,
   input logic             dt_r,
   input logic             den_n,
   input logic             busy,
   input logic             done
);
   // R1
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R2
   ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n && inta_n));
   // R2
   ahi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(a_hi));
   // R3
   wr_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> $past(ale));
   // R3
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (ad_oe && dt_r));
   // R4
   rd_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> !$past(ale));
   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!rd_n, !wr_n, !inta_n}) <= 1);
   // R6
   den_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n || !rd_n || !inta_n) |-> !den_n);
   // R6
   dir_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dt_r |-> wr_n);
   // R9
   ack_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_n |-> !ad_oe);
endmodule

bind mbus_seq mbus_seq_chk #(.AHI_W(ADDR_W - DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ale    (ale),
   .ad_oe  (ad_oe),
   .a_hi   (a_hi),
   .rd_n   (rd_n),
   .wr_n   (wr_n),
   .inta_n (inta_n),
   .dt_r   (dt_r),
   .den_n  (den_n),
   .busy   (busy),
   .done   (done)
);

// File: tb/tb_mbus_seq.sv
`timescale 1ns/1ps
module tb_mbus_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_start, req_io, req_byte, ready;
   logic [1:0]  req_op;
   logic [19:0] req_addr;
   logic [15:0] req_wdata, ad_in, ad_out, rdata;
   logic [3:0]  a_hi;
   logic [9:0]  vec_ptr;
   logic        ad_oe, ale, io_sel, bhe_n, rd_n, wr_n, inta_n, dt_r, den_n, busy, done;

   always #4 clk = ~clk;

   mbus_seq dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
      .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_byte(req_byte), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .io_sel(io_sel), .bhe_n(bhe_n),
      .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .dt_r(dt_r), .den_n(den_n),
      .busy(busy), .done(done), .rdata(rdata), .vec_ptr(vec_ptr)
   );

   typedef struct packed {
      logic        ale, oe;
      logic [15:0] ad;
      logic [3:0]  ahi;
      logic        io, bhe_n, rd_n, wr_n, inta_n, dt_r, den_n, busy, done;
      logic [15:0] rdata;
      logic [9:0]  vec;
      logic        rdy;
      logic [15:0] din;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   string       scen = "R12 reset";
   logic [19:0] m_last = '0;
   logic [15:0] m_rd = '0;
   logic [9:0]  m_vec = '0;

   task automatic chk(string rq, string nm, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] %s actual=%h expected=%h at %0t", rq, scen, nm, act, exp, $time);
      end
   endtask

   function automatic exp_t idle_e();
      exp_t e;
      e        = '0;
      e.ad     = m_last[15:0];
      e.ahi    = m_last[19:16];
      e.bhe_n  = 1'b1;
      e.rd_n   = 1'b1;
      e.wr_n   = 1'b1;
      e.inta_n = 1'b1;
      e.dt_r   = 1'b1;
      e.den_n  = 1'b1;
      e.rdata  = m_rd;
      e.vec    = m_vec;
      return e;
   endfunction

   // apply this clock's stimulus, compare outputs, move to the next falling edge
   task automatic tick(exp_t e);
      ready = e.rdy;
      ad_in = e.din;
      chk("R2",  "ale",     ale,     e.ale);
      chk("R3",  "ad_oe",   ad_oe,   e.oe);
      chk("R7",  "ad_out",  ad_out,  e.ad);
      chk("R2",  "a_hi",    a_hi,    e.ahi);
      chk("R6",  "io_sel",  io_sel,  e.io);
      chk("R7",  "bhe_n",   bhe_n,   e.bhe_n);
      chk("R4",  "rd_n",    rd_n,    e.rd_n);
      chk("R3",  "wr_n",    wr_n,    e.wr_n);
      chk("R9",  "inta_n",  inta_n,  e.inta_n);
      chk("R6",  "dt_r",    dt_r,    e.dt_r);
      chk("R6",  "den_n",   den_n,   e.den_n);
      chk("R1",  "busy",    busy,    e.busy);
      chk("R1",  "done",    done,    e.done);
      chk("R8",  "rdata",   rdata,   e.rdata);
      chk("R10", "vec_ptr", vec_ptr, e.vec);
      @(negedge clk);
   endtask

   // expected clocks of one bus cycle; T-states of two clocks each
   task automatic push_cyc(int op, bit io, bit byt, logic [15:0] wd, int nw,
                           logic [15:0] din, bit second);
      int n;
      n = nw + 4;
      for (int s = 0; s < n; s++) begin
         for (int h = 0; h < 2; h++) begin
            exp_t        e;
            int          kind;
            bit          odd, whole, strb, mid, t4a, take;
            logic [15:0] lane;
            kind  = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 3 : (s == n - 1) ? 5 : 4;
            odd   = m_last[0];
            whole = !byt && !odd;
            lane  = whole ? wd : odd ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
            strb  = (kind == 2 && h == 1) || kind == 3 || kind == 4;
            mid   = kind >= 2 && kind <= 4;
            t4a   = kind == 5 && h == 0;
            take  = (h == 1) && ((kind == 3 && nw == 0) || (kind == 4 && s == n - 2));
            e        = '0;
            e.rdy    = take;
            e.din    = take ? din : ~din;
            e.ale    = (kind == 1);
            e.oe     = (kind == 1 && op != 2) || (op == 1 && (mid || t4a));
            e.ad     = (op == 1 && kind != 1) ? lane : m_last[15:0];
            e.ahi    = m_last[19:16];
            e.io     = (op == 2) || io;
            e.bhe_n  = (op == 2) ? 1'b1 : !(whole || odd);
            e.rd_n   = !(op == 0 && strb);
            e.inta_n = !(op == 2 && strb);
            e.wr_n   = !(op == 1 && mid);
            e.dt_r   = (op == 1);
            e.den_n  = !((op == 1 ? mid : strb) || t4a);
            e.busy   = 1'b1;
            e.done   = (kind == 5 && h == 1 && (op != 2 || second));
            e.rdata  = m_rd;
            e.vec    = m_vec;
            q.push_back(e);
            if (take && op == 0)
               m_rd = whole ? din : odd ? {8'h00, din[15:8]} : {8'h00, din[7:0]};
            if (take && op == 2 && second)
               m_vec = {din[7:0], 2'b00};
         end
      end
   endtask

   task automatic run(int op, bit io, logic [19:0] a, logic [15:0] wd, bit byt,
                      int nw1, logic [15:0] d1, int nw2, logic [15:0] d2, bit poke);
      q.delete();
      req_start = 1'b1;
      req_op    = op[1:0];
      req_io    = io;
      req_addr  = a;
      req_wdata = wd;
      req_byte  = byt;
      tick(idle_e());
      if (op != 2) m_last = a;
      push_cyc(op, io, byt, wd, nw1, d1, 1'b0);
      if (op == 2) push_cyc(op, io, byt, wd, nw2, d2, 1'b1);
      if (poke) begin
         // R11: a conflicting request held high for the whole cycle
         req_op    = 2'd1;
         req_addr  = ~a;
         req_wdata = 16'hDEAD;
      end else begin
         req_start = 1'b0;
      end
      while (q.size() > 0) tick(q.pop_front());
      req_start = 1'b0;
      tick(idle_e());
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_start = 1'b0; req_op = 2'd0; req_io = 1'b0;
      req_addr = '0; req_wdata = '0; req_byte = 1'b0; ready = 1'b0; ad_in = '0;
      repeat (2) @(negedge clk);
      scen = "R12 reset";
      tick(idle_e());
      rst_n = 1'b1;
      tick(idle_e());

      scen = "R4 R8 word read even";
      run(0, 0, 20'hA1234, 16'h0000, 0, 0, 16'hA55A, 0, 0, 0);
      scen = "R3 R5 R6 io word write two waits";
      run(1, 1, 20'h30040, 16'hBEEF, 0, 2, 16'h1111, 0, 0, 0);
      scen = "R7 R8 byte read even one wait";
      run(0, 0, 20'h5F00E, 16'h0000, 1, 1, 16'hC3D4, 0, 0, 0);
      scen = "R7 R8 byte read odd";
      run(0, 1, 20'h5F00F, 16'h0000, 1, 0, 16'hE718, 0, 0, 0);
      scen = "R7 R8 word read odd address";
      run(0, 0, 20'h00101, 16'h0000, 0, 0, 16'h9A2B, 0, 0, 0);
      scen = "R7 byte write odd";
      run(1, 0, 20'hC0003, 16'h0077, 1, 0, 16'h0000, 0, 0, 0);
      scen = "R7 byte write even";
      run(1, 0, 20'hC0004, 16'hFF42, 1, 1, 16'h0000, 0, 0, 0);
      scen = "R9 R10 acknowledge pair";
      run(2, 0, 20'h00000, 16'h0000, 0, 1, 16'h00E1, 0, 16'h002C, 0);
      scen = "R9 R10 acknowledge pair high type";
      run(2, 0, 20'hFFFFF, 16'h0000, 0, 0, 16'h0099, 2, 16'h55FF, 0);
      scen = "R1 unused op code";
      req_start = 1'b1; req_op = 2'd3; req_addr = 20'h77777;
      tick(idle_e());
      req_start = 1'b0;
      tick(idle_e());
      tick(idle_e());
      scen = "R11 busy ignores requests";
      run(0, 0, 20'h8ACE0, 16'h0000, 0, 1, 16'h6D3C, 0, 0, 1);
      scen = "R5 three waits";
      run(0, 1, 20'h2468A, 16'h0000, 0, 3, 16'h0F0F, 0, 0, 0);
      scen = "R11 busy ignores requests during write";
      run(1, 1, 20'h13570, 16'h2B2B, 0, 0, 16'h0000, 0, 0, 1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule